// File: doc/BRIEF.md
# Serial Command Decoder and Addresser

This block sits behind the bit-level two-wire front end of a secure serial memory. It takes whole bytes that the front end has already shifted in, most significant bit first. The first byte after a start condition is a command. Its upper nibble is a chip-select code, and its lower nibble selects the operation and either a zone number or a password selector. For every byte received, the block returns an acknowledge decision that the front end drives onto the ninth clock (0 on the line means acknowledged). It sends its own bytes back when the front end asks for the next one.

For memory commands, the second byte gives an offset inside one of four 64-byte zones. The block then produces the byte addresses for the storage array. Reads advance through the whole zone and wrap inside it. Writes advance only inside the current 8-byte page. The block also carries a checksum window. A successful authentication permits it once. The first write command after that opens it. A later read of the configuration zone at offset 0x20 then returns eight bytes from an external checksum source in place of stored data. The block also classifies the remaining commands (password, authentication and fuse commands) for the units that handle them, and it answers the fuse-read command by itself.

Top module: `serial_cmd_addresser`

## Requirements
- R1: The first byte after a start is acknowledged (ack_o=1 one cycle after rx_valid_i) when its bits 7..4 equal 4'b1011 or equal cfg_cs_i.
- R2: A command byte whose bits 7..4 match neither code is not acknowledged (ack_o=0). Every later byte is also left unacknowledged until the next start.
- R3: On an accepted command byte, cmd_stb_o pulses and cmd_kind_o reports the operation decoded from bits 3..0: xx00 write=0, xx01 read=1, xx11 verify password=2, 0010 init auth=3, 0110 verify auth=4, 1010 write fuse=5, 1110 read fuse=6. cmd_sel_o carries bits 3..2 (the zone for memory commands).
- R4: cmd_global_o is 1 only for a write or verify-password command that was accepted through the fixed code 4'b1011.
- R5: After a read command with zone z and an address byte a, bytes are returned from {z, a[5:0]}, then from the following offsets. The offset wraps from 63 to 0 inside zone z. Address bits 7..6 are ignored.
- R6: Each data byte of a write command produces one mem_wr_o pulse with mem_waddr_o={z, offset}. Only the low 3 offset bits advance, wrapping inside the 8-byte page.
- R7: After an auth_ok_i pulse, the next write command opens the checksum window. A following read of zone 3 at offset 0x20 returns csum_byte_i for indices 0..7, then stored bytes from offset 0x28 onward.
- R8: The window opens at most once per auth_ok_i pulse. It closes after eight checksum bytes, on a stop during the checksum read, or when a read command starts at any other address.
- R9: The read-fuse command returns {5'b0, fuse_i} for every byte requested.
- R10: tx_valid_o follows each tx_req_i by one cycle in a read or fuse-read transfer. Data bytes of write, password and authentication commands are acknowledged.
- R11: After reset, no acknowledge, write or transmit is active, and a byte that arrives without a preceding start is not acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start_i | input | 1 | Start condition seen (one-cycle pulse) |
| stop_i | input | 1 | Stop condition seen (one-cycle pulse) |
| rx_valid_i | input | 1 | A received byte is present |
| rx_byte_i | input | 8 | Received byte |
| ack_valid_o | output | 1 | Acknowledge decision is valid |
| ack_o | output | 1 | 1: acknowledge the byte, 0: leave it unacknowledged |
| tx_req_i | input | 1 | Front end asks for the next byte to send |
| tx_valid_o | output | 1 | tx_byte_o holds the requested byte |
| tx_byte_o | output | 8 | Byte to send |
| cfg_cs_i | input | 4 | Programmable chip-select code |
| fuse_i | input | 3 | Fuse states {PER, CMA, FAB} |
| auth_ok_i | input | 1 | Pulse on a successful authentication |
| cmd_stb_o | output | 1 | Command accepted |
| cmd_kind_o | output | 3 | Decoded operation code |
| cmd_sel_o | output | 2 | Command bits 3..2 |
| cmd_global_o | output | 1 | Command was addressed to all devices |
| mem_raddr_o | output | 8 | Read address {zone, offset} |
| mem_rdata_i | input | 8 | Read data for mem_raddr_o (same cycle) |
| mem_rd_o | output | 1 | A stored byte is consumed |
| mem_wr_o | output | 1 | Write strobe |
| mem_waddr_o | output | 8 | Write address |
| mem_wdata_o | output | 8 | Write data |
| csum_idx_o | output | 3 | Checksum byte index |
| csum_byte_i | input | 8 | Checksum byte for csum_idx_o |
| csum_rd_o | output | 1 | A checksum byte is consumed |

## Verification
A wrong address pointer shows up as the wrong stored byte on the next tx_byte_o after a zone or page boundary. It can also show up as a mem_waddr_o that leaves its page on the third write of a burst near the page end. A checksum window left open, or opened twice, shows up one request later as a csum_byte_i pattern where a stored byte was due at offset 0x20. A wrong chip-select or state decision is visible one cycle after the byte, on ack_o, and it stays visible on every later byte of the same transfer.

// File: rtl/sca_pkg.sv
package sca_pkg;
  localparam int CMD_W = 8;
  localparam int CS_W  = 4;
  localparam logic [CS_W-1:0] CS_FIXED = 4'b1011;

  typedef enum logic [2:0] {
    K_WRITE = 3'd0,
    K_READ  = 3'd1,
    K_VPW   = 3'd2,
    K_IAUTH = 3'd3,
    K_VAUTH = 3'd4,
    K_WFUSE = 3'd5,
    K_RFUSE = 3'd6,
    K_NONE  = 3'd7
  } cmd_kind_e;

  // operation from the low nibble of a command byte
  function automatic cmd_kind_e classify(input logic [3:0] ins);
    cmd_kind_e k;
    case (ins[1:0])
      2'b00:   k = K_WRITE;
      2'b01:   k = K_READ;
      2'b11:   k = K_VPW;
      default: begin
        case (ins[3:2])
          2'b00:   k = K_IAUTH;
          2'b01:   k = K_VAUTH;
          2'b10:   k = K_WFUSE;
          default: k = K_RFUSE;
        endcase
      end
    endcase
    return k;
  endfunction

  function automatic logic may_be_global(input cmd_kind_e k);
    return (k == K_WRITE) || (k == K_VPW);
  endfunction
endpackage

// File: rtl/sca_cmd_decode.sv
module sca_cmd_decode
  import sca_pkg::*;
(
  input  logic [CMD_W-1:0] byte_i,
  input  logic [CS_W-1:0]  cfg_cs_i,
  output logic             hit_o,
  output cmd_kind_e        kind_o,
  output logic             global_o
);
  logic fixed_hit, prog_hit;

  assign fixed_hit = (byte_i[CMD_W-1 -: CS_W] == CS_FIXED);
  assign prog_hit  = (byte_i[CMD_W-1 -: CS_W] == cfg_cs_i);
  assign hit_o     = fixed_hit | prog_hit;
  assign kind_o    = classify(byte_i[3:0]);
  assign global_o  = fixed_hit & may_be_global(kind_o);

  always_comb begin
    AST_GLOBAL_IS_MATCH: assert (!global_o || hit_o); // R4
  end
endmodule

// File: rtl/sca_addr_gen.sv
module sca_addr_gen #(
  parameter int ZONE_W = 2,
  parameter int OFF_W  = 6,
  parameter int PAGE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ZONE_W-1:0] load_zone_i,
  input  logic [OFF_W-1:0]  load_off_i,
  input  logic              rd_step_i,
  input  logic              wr_step_i,
  output logic [ZONE_W-1:0] zone_o,
  output logic [OFF_W-1:0]  off_o
);
  // reads run through the whole zone and wrap inside it
  function automatic logic [OFF_W-1:0] rd_next(input logic [OFF_W-1:0] o);
    return o + 1'b1;
  endfunction

  // writes advance only inside the page
  function automatic logic [OFF_W-1:0] wr_next(input logic [OFF_W-1:0] o);
    logic [PAGE_W-1:0] lo;
    lo = o[PAGE_W-1:0] + 1'b1;
    return {o[OFF_W-1:PAGE_W], lo};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      zone_o <= '0;
      off_o  <= '0;
    end else if (load_i) begin
      zone_o <= load_zone_i;
      off_o  <= load_off_i;
    end else if (rd_step_i) begin
      off_o <= rd_next(off_o);
    end else if (wr_step_i) begin
      off_o <= wr_next(off_o);
    end
  end

  AST_RD_ZONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_step_i && !load_i |=> zone_o == $past(zone_o)); // R5
  AST_WR_PAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_step_i && !load_i |=> (zone_o == $past(zone_o)) &&
      (off_o[OFF_W-1:PAGE_W] == $past(off_o[OFF_W-1:PAGE_W]))); // R6
endmodule

// File: rtl/sca_csum_win.sv
module sca_csum_win #(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             auth_ok_i,
  input  logic             wr_cmd_i,
  input  logic             rd_hit_i,
  input  logic             rd_miss_i,
  input  logic             step_i,
  input  logic             end_i,
  output logic             active_o,
  output logic [IDX_W-1:0] idx_o
);
  logic avail_q, mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      avail_q  <= 1'b0;
      mode_q   <= 1'b0;
      active_o <= 1'b0;
      idx_o    <= '0;
    end else if (auth_ok_i) begin
      avail_q  <= 1'b1;
      mode_q   <= 1'b0;
      active_o <= 1'b0;
    end else begin
      if (wr_cmd_i && avail_q) begin
        mode_q  <= 1'b1;
        avail_q <= 1'b0;
      end
      if (rd_hit_i && mode_q) begin
        active_o <= 1'b1;
        idx_o    <= '0;
      end else if (rd_miss_i) begin
        mode_q <= 1'b0;
      end
      if (active_o && end_i) begin
        active_o <= 1'b0;
        mode_q   <= 1'b0;
      end else if (active_o && step_i) begin
        idx_o <= idx_o + 1'b1;
        if (idx_o == '1) begin
          active_o <= 1'b0;
          mode_q   <= 1'b0;
        end
      end
    end
  end

  AST_CSUM_AFTER_WR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode_q) |-> $past(wr_cmd_i)); // R7
  AST_CSUM_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode_q) |-> $fell(avail_q)); // R8
endmodule

// File: rtl/serial_cmd_addresser.sv
module serial_cmd_addresser
  import sca_pkg::*;
#(
  parameter int ZONE_W = 2,
  parameter int OFF_W  = 6,
  parameter int PAGE_W = 3,
  parameter int IDX_W  = 3,
  parameter int FUSE_W = 3,
  parameter logic [OFF_W-1:0] CAR_OFF = 6'h20,
  localparam int AW = ZONE_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              rx_valid_i,
  input  logic [CMD_W-1:0]  rx_byte_i,
  output logic              ack_valid_o,
  output logic              ack_o,
  input  logic              tx_req_i,
  output logic              tx_valid_o,
  output logic [CMD_W-1:0]  tx_byte_o,
  input  logic [CS_W-1:0]   cfg_cs_i,
  input  logic [FUSE_W-1:0] fuse_i,
  input  logic              auth_ok_i,
  output logic              cmd_stb_o,
  output logic [2:0]        cmd_kind_o,
  output logic [1:0]        cmd_sel_o,
  output logic              cmd_global_o,
  output logic [AW-1:0]     mem_raddr_o,
  input  logic [CMD_W-1:0]  mem_rdata_i,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic [AW-1:0]     mem_waddr_o,
  output logic [CMD_W-1:0]  mem_wdata_o,
  output logic [IDX_W-1:0]  csum_idx_o,
  input  logic [CMD_W-1:0]  csum_byte_i,
  output logic              csum_rd_o
);
  localparam logic [ZONE_W-1:0] CFG_ZONE = '1;

  typedef enum logic [2:0] {
    S_IDLE, S_CMD, S_ADDR, S_WDATA, S_RDATA, S_FUSE, S_PARAM
  } st_e;

  st_e               state;
  cmd_kind_e         kind_q;
  logic [ZONE_W-1:0] zone_q;

  // decoder outputs
  logic      cs_hit, cs_global;
  cmd_kind_e cs_kind;

  // named internal events
  logic              byte_ev, addr_load, wr_step, rd_step, wr_cmd;
  logic              car_hit, car_miss, xfer_end, csum_active;
  logic [ZONE_W-1:0] zone_w;
  logic [OFF_W-1:0]  off_w;

  sca_cmd_decode u_dec (
    .byte_i   (rx_byte_i),
    .cfg_cs_i (cfg_cs_i),
    .hit_o    (cs_hit),
    .kind_o   (cs_kind),
    .global_o (cs_global)
  );

  assign byte_ev   = rx_valid_i && !start_i && !stop_i;
  assign addr_load = byte_ev && (state == S_ADDR);
  assign wr_step   = byte_ev && (state == S_WDATA);
  assign rd_step   = tx_req_i && !start_i && !stop_i && (state == S_RDATA);
  assign wr_cmd    = byte_ev && (state == S_CMD) && cs_hit && (cs_kind == K_WRITE);
  assign car_hit   = addr_load && (kind_q == K_READ) && (zone_q == CFG_ZONE) &&
                     (rx_byte_i[OFF_W-1:0] == CAR_OFF);
  assign car_miss  = addr_load && (kind_q == K_READ) && !car_hit;
  assign xfer_end  = start_i | stop_i;

  sca_addr_gen #(.ZONE_W(ZONE_W), .OFF_W(OFF_W), .PAGE_W(PAGE_W)) u_addr (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (addr_load),
    .load_zone_i (zone_q),
    .load_off_i  (rx_byte_i[OFF_W-1:0]),
    .rd_step_i   (rd_step),
    .wr_step_i   (wr_step),
    .zone_o      (zone_w),
    .off_o       (off_w)
  );

  sca_csum_win #(.IDX_W(IDX_W)) u_csum (
    .clk       (clk),
    .rst_n     (rst_n),
    .auth_ok_i (auth_ok_i),
    .wr_cmd_i  (wr_cmd),
    .rd_hit_i  (car_hit),
    .rd_miss_i (car_miss),
    .step_i    (rd_step),
    .end_i     (xfer_end),
    .active_o  (csum_active),
    .idx_o     (csum_idx_o)
  );

  assign mem_raddr_o = {zone_w, off_w};
  assign mem_rd_o    = rd_step && !csum_active;
  assign csum_rd_o   = rd_step && csum_active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= S_IDLE;
      kind_q       <= K_NONE;
      zone_q       <= '0;
      ack_valid_o  <= 1'b0;
      ack_o        <= 1'b0;
      tx_valid_o   <= 1'b0;
      tx_byte_o    <= '0;
      cmd_stb_o    <= 1'b0;
      cmd_kind_o   <= '0;
      cmd_sel_o    <= '0;
      cmd_global_o <= 1'b0;
      mem_wr_o     <= 1'b0;
      mem_waddr_o  <= '0;
      mem_wdata_o  <= '0;
    end else begin
      ack_valid_o <= 1'b0;
      ack_o       <= 1'b0;
      tx_valid_o  <= 1'b0;
      cmd_stb_o   <= 1'b0;
      mem_wr_o    <= 1'b0;
      if (start_i) begin
        state <= S_CMD;
      end else if (stop_i) begin
        state <= S_IDLE;
      end else if (rx_valid_i) begin
        ack_valid_o <= 1'b1;
        case (state)
          S_CMD: begin
            if (cs_hit) begin
              ack_o        <= 1'b1;
              cmd_stb_o    <= 1'b1;
              cmd_kind_o   <= cs_kind;
              cmd_sel_o    <= rx_byte_i[3:2];
              cmd_global_o <= cs_global;
              kind_q       <= cs_kind;
              zone_q       <= rx_byte_i[3:2];
              case (cs_kind)
                K_WRITE, K_READ: state <= S_ADDR;
                K_RFUSE:         state <= S_FUSE;
                default:         state <= S_PARAM;
              endcase
            end else begin
              state <= S_IDLE;
            end
          end
          S_ADDR: begin
            ack_o <= 1'b1;
            state <= (kind_q == K_WRITE) ? S_WDATA : S_RDATA;
          end
          S_WDATA: begin
            ack_o       <= 1'b1;
            mem_wr_o    <= 1'b1;
            mem_waddr_o <= {zone_w, off_w};
            mem_wdata_o <= rx_byte_i;
          end
          S_PARAM: ack_o <= 1'b1;
          default: ack_o <= 1'b0;
        endcase
      end else if (tx_req_i) begin
        if (state == S_RDATA) begin
          tx_valid_o <= 1'b1;
          tx_byte_o  <= csum_active ? csum_byte_i : mem_rdata_i;
        end else if (state == S_FUSE) begin
          tx_valid_o <= 1'b1;
          tx_byte_o  <= {{(CMD_W-FUSE_W){1'b0}}, fuse_i};
        end
      end
    end
  end

  AST_NACK_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    byte_ev && (state == S_CMD) && (rx_byte_i[7:4] != CS_FIXED) &&
    (rx_byte_i[7:4] != cfg_cs_i) |=> ack_valid_o && !ack_o); // R2
  AST_IDLE_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    byte_ev && (state == S_IDLE) |=> !ack_o); // R11
  AST_CAR_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    csum_active |-> (zone_w == CFG_ZONE) &&
      (off_w[OFF_W-1:IDX_W] == CAR_OFF[OFF_W-1:IDX_W])); // R7
  AST_FUSE_PAD: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_FUSE) && tx_req_i && !start_i && !stop_i && !rx_valid_i
      |=> tx_byte_o[CMD_W-1:FUSE_W] == '0); // R9
  AST_TX_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid_o |-> $past(tx_req_i)); // R10
endmodule

// File: tb/serial_cmd_addresser_test.sv
module serial_cmd_addresser_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0, stop_i = 1'b0, rx_valid_i = 1'b0, tx_req_i = 1'b0;
  logic [7:0] rx_byte_i = '0;
  logic [3:0] cfg_cs_i = 4'h5;
  logic [2:0] fuse_i = 3'b101;
  logic       auth_ok_i = 1'b0;
  logic       ack_valid_o, ack_o, tx_valid_o, cmd_stb_o, cmd_global_o;
  logic [7:0] tx_byte_o, mem_raddr_o, mem_rdata_i, mem_waddr_o, mem_wdata_o, csum_byte_i;
  logic [2:0] cmd_kind_o, csum_idx_o;
  logic [1:0] cmd_sel_o;
  logic       mem_rd_o, mem_wr_o, csum_rd_o;

  logic [7:0] mem [256];
  int n_run = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign mem_rdata_i = mem[mem_raddr_o];
  assign csum_byte_i = 8'hC0 | {5'b0, csum_idx_o};

  serial_cmd_addresser uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
    .rx_valid_i(rx_valid_i), .rx_byte_i(rx_byte_i),
    .ack_valid_o(ack_valid_o), .ack_o(ack_o),
    .tx_req_i(tx_req_i), .tx_valid_o(tx_valid_o), .tx_byte_o(tx_byte_o),
    .cfg_cs_i(cfg_cs_i), .fuse_i(fuse_i), .auth_ok_i(auth_ok_i),
    .cmd_stb_o(cmd_stb_o), .cmd_kind_o(cmd_kind_o), .cmd_sel_o(cmd_sel_o),
    .cmd_global_o(cmd_global_o),
    .mem_raddr_o(mem_raddr_o), .mem_rdata_i(mem_rdata_i), .mem_rd_o(mem_rd_o),
    .mem_wr_o(mem_wr_o), .mem_waddr_o(mem_waddr_o), .mem_wdata_o(mem_wdata_o),
    .csum_idx_o(csum_idx_o), .csum_byte_i(csum_byte_i), .csum_rd_o(csum_rd_o)
  );

  // {cfg_cs, cmd byte, expect ack, expect kind, expect global}
  localparam int NV = 12;
  localparam logic [16:0] VEC [NV] = '{
    {4'h5, 8'hB0, 1'b1, 3'd0, 1'b1},
    {4'h5, 8'h50, 1'b1, 3'd0, 1'b0},
    {4'h5, 8'hBD, 1'b1, 3'd1, 1'b0},
    {4'h5, 8'h5F, 1'b1, 3'd2, 1'b0},
    {4'h5, 8'hB7, 1'b1, 3'd2, 1'b1},
    {4'h5, 8'hB2, 1'b1, 3'd3, 1'b0},
    {4'h5, 8'h56, 1'b1, 3'd4, 1'b0},
    {4'h5, 8'hBA, 1'b1, 3'd5, 1'b0},
    {4'h5, 8'h5E, 1'b1, 3'd6, 1'b0},
    {4'h5, 8'h30, 1'b0, 3'd0, 1'b0},
    {4'h3, 8'h30, 1'b1, 3'd0, 1'b0},
    {4'h3, 8'h50, 1'b0, 3'd0, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
  endtask

  task automatic pulse_stop();
    @(negedge clk) stop_i = 1'b1;
    @(negedge clk) stop_i = 1'b0;
  endtask

  task automatic pulse_auth();
    @(negedge clk) auth_ok_i = 1'b1;
    @(negedge clk) auth_ok_i = 1'b0;
  endtask

  task automatic send(input logic [7:0] b, output logic ackv, output logic ack);
    @(negedge clk) begin rx_valid_i = 1'b1; rx_byte_i = b; end
    @(negedge clk) rx_valid_i = 1'b0;
    ackv = ack_valid_o;
    ack  = ack_o;
  endtask

  task automatic fetch(output logic v, output logic [7:0] b);
    @(negedge clk) tx_req_i = 1'b1;
    @(negedge clk) tx_req_i = 1'b0;
    v = tx_valid_o;
    b = tx_byte_o;
  endtask

  // start, command, address
  task automatic open_cmd(input logic [7:0] c, input logic [7:0] a);
    logic av, ak;
    pulse_start();
    send(c, av, ak);
    send(a, av, ak);
  endtask

  task automatic read_expect(input string req, input logic [7:0] exp);
    logic v;
    logic [7:0] b;
    fetch(v, b);
    chk(req, {23'b0, v, b}, {23'b0, 1'b1, exp});
  endtask

  task automatic write_one(input logic [7:0] c, input logic [7:0] a, input logic [7:0] d);
    logic av, ak;
    open_cmd(c, a);
    send(d, av, ak);
    pulse_stop();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not end");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic av, ak, v;
    logic [7:0] b;
    for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'hA5;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11 ack_valid at reset", {31'b0, ack_valid_o}, 0);
    chk("R11 mem_wr at reset", {31'b0, mem_wr_o}, 0);
    chk("R11 tx_valid at reset", {31'b0, tx_valid_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    send(8'hB0, av, ak);
    chk("R11 byte without start not acked", {30'b0, av, ak}, {30'b0, 2'b10});

    // R1 R3 R4 table walk
    for (int i = 0; i < NV; i++) begin
      logic stb;
      cfg_cs_i = VEC[i][16:13];
      pulse_start();
      @(negedge clk) begin rx_valid_i = 1'b1; rx_byte_i = VEC[i][12:5]; end
      @(negedge clk) rx_valid_i = 1'b0;
      stb = cmd_stb_o;
      chk("R1 command ack", {31'b0, ack_o}, {31'b0, VEC[i][4]});
      if (VEC[i][4]) begin
        chk("R3 command kind", {29'b0, cmd_kind_o}, {29'b0, VEC[i][3:1]});
        chk("R3 command select", {30'b0, cmd_sel_o}, {30'b0, VEC[i][8:7]});
        chk("R4 global flag", {31'b0, cmd_global_o}, {31'b0, VEC[i][0]});
      end else begin
        chk("R2 no strobe on miss", {31'b0, stb}, 0);
      end
      pulse_stop();
    end
    cfg_cs_i = 4'h5;

    // R2: later bytes after a miss stay unacknowledged until a start
    pulse_start();
    send(8'h30, av, ak);
    send(8'h00, av, ak);
    chk("R2 byte after miss", {30'b0, av, ak}, {30'b0, 2'b10});
    pulse_start();
    send(8'hB0, av, ak);
    chk("R2 new start reopens", {31'b0, ak}, 1);
    pulse_stop();

    // R5: read zone 1 from offset 0x3E, wraps inside the zone; bits 7..6 ignored
    open_cmd(8'hB5, 8'hFE);
    read_expect("R5 read first", mem[8'h7E]);
    read_expect("R5 read second", mem[8'h7F]);
    read_expect("R5 read wrap in zone", mem[8'h40]);
    pulse_stop();

    // R6: write zone 2 from offset 0x06, wraps inside the page
    open_cmd(8'hB8, 8'h06);
    send(8'h11, av, ak);
    chk("R6 write addr 1", {16'b0, mem_wr_o, ak, 6'b0, mem_waddr_o}, {16'b0, 2'b11, 6'b0, 8'h86});
    send(8'h22, av, ak);
    chk("R6 write addr 2", {23'b0, mem_wr_o, mem_waddr_o}, {23'b0, 1'b1, 8'h87});
    send(8'h33, av, ak);
    chk("R6 write page wrap", {15'b0, mem_wr_o, mem_waddr_o, mem_wdata_o}, {15'b0, 1'b1, 8'h80, 8'h33});
    pulse_stop();

    // R10: verify-password data bytes are acknowledged
    pulse_start();
    send(8'hB3, av, ak);
    send(8'h12, av, ak);
    chk("R10 password byte acked", {30'b0, av, ak}, {30'b0, 2'b11});
    pulse_stop();

    // R7: checksum window after authentication and write
    pulse_auth();
    write_one(8'hB0, 8'h00, 8'h01);
    open_cmd(8'hBD, 8'h20);
    for (int k = 0; k < 8; k++) read_expect("R7 checksum byte", 8'hC0 | 8'(k));
    read_expect("R7 after checksum 0x28", mem[8'hE8]);
    read_expect("R7 after checksum 0x29", mem[8'hE9]);
    pulse_stop();

    // R8: only once per authentication
    write_one(8'hB0, 8'h00, 8'h02);
    open_cmd(8'hBD, 8'h20);
    read_expect("R8 second window refused", mem[8'hE0]);
    pulse_stop();

    // R8: read at another address closes the window
    pulse_auth();
    write_one(8'hB0, 8'h00, 8'h03);
    open_cmd(8'hBD, 8'h10);
    read_expect("R8 other address normal", mem[8'hD0]);
    pulse_stop();
    open_cmd(8'hBD, 8'h20);
    read_expect("R8 closed by other read", mem[8'hE0]);
    pulse_stop();

    // R8: stop during checksum read closes it
    pulse_auth();
    write_one(8'hB0, 8'h00, 8'h04);
    open_cmd(8'hBD, 8'h20);
    read_expect("R8 partial checksum 0", 8'hC0);
    read_expect("R8 partial checksum 1", 8'hC1);
    pulse_stop();
    open_cmd(8'hBD, 8'h20);
    read_expect("R8 closed by stop", mem[8'hE0]);
    pulse_stop();

    // R9: fuse read repeats
    pulse_start();
    send(8'hBE, av, ak);
    for (int k = 0; k < 3; k++) begin
      fetch(v, b);
      chk("R9 fuse byte", {23'b0, v, b}, {23'b0, 1'b1, 8'h05});
    end
    pulse_stop();

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule